// File: doc/BRIEF.md
# Valley-Skipping Switch Timing Controller

This block decides when the main switch of a quasi-resonant flyback converter turns on and off. After each turn-off it waits for a chosen number of resonant valleys, which it sees as pulses from a zero-crossing comparator, and then raises the gate command. Skipping more valleys at light load lowers the switching frequency. The number of valleys to wait for comes from a saturating up/down counter, the valley target. The counter moves at most one step per slow update tick, based on what three feedback comparators reported during the tick period.

Two guards keep the off phase well behaved. A ringing-suppression window follows each turn-off, and its length depends on whether the zero-crossing voltage sits above a suppression level. A maximum off time forces a turn-on when too few valleys arrive. In the on phase, leading-edge blanking masks the current-sense trip for a minimum on time, and a maximum on time forces the gate off. A start-up initialisation and a force-to-one request bring the valley target back to one, so the converter can react quickly to a load step.

Top module: `qr_valley_timer`

## Requirements
- R1: After reset, or in the cycle after `init_req` is sampled high, `gate` is 0 and `valley_target` is 1.
- R2: A tick fires every `TICK_CYC` clocks. If `fb_gt_low` was 0 in every cycle of the period, the tick raises `valley_target` by one, and the value saturates at `CNT_MAX` (7).
- R3: If `fb_gt_low` was 1 in at least one cycle of the period and `fb_gt_high` was 0 in every cycle, the tick leaves `valley_target` unchanged.
- R4: If `fb_gt_high` was 1 in at least one cycle of the period, the tick lowers `valley_target` by one, and the value saturates at 1.
- R5: When `fb_gt_reset` or `force_one` is sampled high, `valley_target` is 1 from the next cycle. This takes priority over a tick.
- R6: The valley count is cleared when the gate turns on. While the gate is off, it increments on each sampled `zc_fall` pulse and saturates at `CNT_MAX`. It does not wrap.
- R7: After turn-off, the gate stays off for at least `RS_SHORT_CYC` cycles when `zc_above_rs` is 1, and for at least `RS_LONG_CYC` cycles when `zc_above_rs` is 0.
- R8: Once the suppression window has passed, the gate turns on at the first clock edge where the registered valley count is at least `valley_target`.
- R9: The gate is never off for more than `OFF_MAX_CYC` consecutive cycles. It turns on at that limit whatever the counts are.
- R10: A `cs_trip` sampled during the first `LEB_CYC`-1 on cycles has no effect, so every on pulse lasts at least `LEB_CYC` cycles.
- R11: A `cs_trip` sampled at or after on cycle index `LEB_CYC`-1 drives `gate` low at that clock edge.
- R12: The gate is never on for more than `ON_MAX_CYC` consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_gt_low | input | 1 | Feedback is above the low hysteresis threshold |
| fb_gt_high | input | 1 | Feedback is above the high hysteresis threshold |
| fb_gt_reset | input | 1 | Feedback is above the fast-reset threshold |
| zc_fall | input | 1 | Single-cycle pulse on a falling zero crossing |
| zc_above_rs | input | 1 | Zero-crossing voltage is above the suppression level |
| cs_trip | input | 1 | Current-sense comparator has tripped |
| init_req | input | 1 | Synchronous start-up initialisation |
| force_one | input | 1 | Request to set the valley target to one |
| gate | output | 1 | Gate command for the main switch |
| valley_target | output | $clog2(CNT_MAX+1) | Present valley target |

## Verification
A wrong valley target shows up at two places. The `valley_target` port shows it no later than the cycle after the tick. The off-time length of the next full switching cycle also changes, by at least one zero-crossing interval. A valley count that is not cleared, wraps instead of saturating, or counts during the on phase produces an off time that differs from the one expected for that crossing pattern, and this is visible on the first off phase after the fault. Timer faults show up within one switching cycle as an on or off pulse length that differs from the blanking, suppression or limit values.

// File: rtl/qr_valley_timer.sv
module qr_valley_timer #(
  parameter int TICK_CYC     = 6000000,
  parameter int RS_SHORT_CYC = 313,
  parameter int RS_LONG_CYC  = 3125,
  parameter int OFF_MAX_CYC  = 5250,
  parameter int LEB_CYC      = 41,
  parameter int ON_MAX_CYC   = 3750,
  parameter int CNT_MAX      = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_gt_low,
  input  logic fb_gt_high,
  input  logic fb_gt_reset,
  input  logic zc_fall,
  input  logic zc_above_rs,
  input  logic cs_trip,
  input  logic init_req,
  input  logic force_one,
  output logic gate,
  output logic [$clog2(CNT_MAX+1)-1:0] valley_target
);

  localparam int CW  = $clog2(CNT_MAX + 1);
  localparam int TKW = $clog2(TICK_CYC + 1);
  localparam int TMX = (OFF_MAX_CYC > ON_MAX_CYC) ? OFF_MAX_CYC : ON_MAX_CYC;
  localparam int TW  = $clog2(TMX + 1);

  localparam logic [TKW-1:0] TICK_LAST = TKW'(TICK_CYC - 1);
  localparam logic [TW-1:0]  RS_S_LAST = TW'(RS_SHORT_CYC - 1);
  localparam logic [TW-1:0]  RS_L_LAST = TW'(RS_LONG_CYC - 1);
  localparam logic [TW-1:0]  OFF_LAST  = TW'(OFF_MAX_CYC - 1);
  localparam logic [TW-1:0]  LEB_LAST  = TW'(LEB_CYC - 1);
  localparam logic [TW-1:0]  ON_LAST   = TW'(ON_MAX_CYC - 1);
  localparam logic [TW-1:0]  OFF_LIM   = TW'(OFF_MAX_CYC);
  localparam logic [TW-1:0]  ON_LIM    = TW'(ON_MAX_CYC);
  localparam logic [CW-1:0]  CMAX      = CW'(CNT_MAX);
  localparam logic [CW-1:0]  CONE      = CW'(1);

  // Tick period and feedback history
  logic [TKW-1:0] tick_cnt;
  logic           seen_lo, seen_hi;
  logic           tick, any_lo, any_hi, to_one;

  assign tick   = (tick_cnt == TICK_LAST);
  assign any_lo = seen_lo | fb_gt_low;
  assign any_hi = seen_hi | fb_gt_high;
  assign to_one = fb_gt_reset | force_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt      <= '0;
      seen_lo       <= 1'b0;
      seen_hi       <= 1'b0;
      valley_target <= CONE;
    end else if (init_req) begin
      tick_cnt      <= '0;
      seen_lo       <= 1'b0;
      seen_hi       <= 1'b0;
      valley_target <= CONE;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      seen_lo  <= tick ? 1'b0 : any_lo;
      seen_hi  <= tick ? 1'b0 : any_hi;
      if (to_one) begin
        valley_target <= CONE;
      end else if (tick) begin
        if (!any_lo) begin
          if (valley_target < CMAX) valley_target <= valley_target + 1'b1;
        end else if (any_hi) begin
          if (valley_target > CONE) valley_target <= valley_target - 1'b1;
        end
      end
    end
  end

  // Switching phase timer and valley count
  logic [TW-1:0] tmr;
  logic [CW-1:0] zc_cnt;
  logic [TW-1:0] rs_last;
  logic          rs_done, turn_on, turn_off;

  assign rs_last  = zc_above_rs ? RS_S_LAST : RS_L_LAST;
  assign rs_done  = (tmr >= rs_last);
  assign turn_on  = !gate && ((rs_done && (zc_cnt >= valley_target)) || (tmr == OFF_LAST));
  assign turn_off = gate && (((tmr >= LEB_LAST) && cs_trip) || (tmr == ON_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate <= 1'b0;
      tmr  <= '0;
    end else if (init_req) begin
      gate <= 1'b0;
      tmr  <= '0;
    end else if (turn_on) begin
      gate <= 1'b1;
      tmr  <= '0;
    end else if (turn_off) begin
      gate <= 1'b0;
      tmr  <= '0;
    end else begin
      tmr  <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_cnt <= '0;
    end else if (init_req || turn_on) begin
      zc_cnt <= '0;
    end else if (!gate && zc_fall && (zc_cnt < CMAX)) begin
      zc_cnt <= zc_cnt + 1'b1;
    end
  end

  // Assertions
  p_target_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_target >= CONE) && (valley_target <= CMAX));

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_req && !force_one && !fb_gt_reset) |=>
      ((valley_target == $past(valley_target)) ||
       (valley_target == $past(valley_target) + 1'b1) ||
       (valley_target + 1'b1 == $past(valley_target))));

  p_force_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_one || fb_gt_reset) |=> (valley_target == CONE));

  p_zc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (zc_cnt == '0));

  p_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(tmr) >= RS_S_LAST));

  p_off_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> (tmr < OFF_LIM));

  p_blanking_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && (tmr < LEB_LAST) && !init_req) |=> gate);

  p_on_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (tmr < ON_LIM));

endmodule

// File: tb/qr_valley_timer_tb.sv
module qr_valley_timer_tb;
  localparam int TICK = 40, RSS = 3, RSL = 10, OFFM = 30, LEB = 4, ONM = 12, CMX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_gt_low = 0, fb_gt_high = 0, fb_gt_reset = 0, zc_fall = 0;
  logic zc_above_rs = 0, cs_trip = 0, init_req = 0, force_one = 0;
  logic gate;
  logic [2:0] valley_target;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qr_valley_timer #(
    .TICK_CYC(TICK), .RS_SHORT_CYC(RSS), .RS_LONG_CYC(RSL), .OFF_MAX_CYC(OFFM),
    .LEB_CYC(LEB), .ON_MAX_CYC(ONM), .CNT_MAX(CMX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .fb_gt_low(fb_gt_low), .fb_gt_high(fb_gt_high),
    .fb_gt_reset(fb_gt_reset), .zc_fall(zc_fall), .zc_above_rs(zc_above_rs),
    .cs_trip(cs_trip), .init_req(init_req), .force_one(force_one),
    .gate(gate), .valley_target(valley_target)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_off(input int n, input int p, input bit above);
    int rs = above ? RSS : RSL;
    for (int k = rs - 1; k < OFFM - 1; k++) begin
      int c = (p == 0) ? 0 : (k + p - 1) / p;
      if (c > CMX) c = CMX;
      if (c >= n) return k + 1;
    end
    return OFFM;
  endfunction

  // trip_mode: 0 none, 1 always, 2 only during first LEB-1 on cycles, 3 only at on index 6
  task automatic measure(input int trip_mode, input int p, output int on_len, output int off_len);
    int idx;
    zc_fall = 0;
    cs_trip = (trip_mode == 1);
    while (gate !== 1'b0) @(negedge clk);
    while (gate !== 1'b1) @(negedge clk);
    on_len = 0;
    while (gate === 1'b1) begin
      if (trip_mode == 2) cs_trip = (on_len < LEB - 1);
      if (trip_mode == 3) cs_trip = (on_len == 6);
      on_len++;
      @(negedge clk);
    end
    cs_trip = (trip_mode == 1);
    idx = 0;
    while (gate === 1'b0) begin
      zc_fall = (p != 0) && (idx % p == 0);
      idx++;
      @(negedge clk);
    end
    zc_fall = 0;
    off_len = idx;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int on_len, off_len;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 gate at reset", gate, 0);
    check("R1 target at reset", valley_target, 1);
    rst_n = 1'b1;

    // R2: all-low periods count up and saturate at 7
    repeat (5) @(negedge clk);
    for (int k = 0; k <= 8; k++) begin
      check("R2 count up", valley_target, (k + 1 > 7) ? 7 : k + 1);
      repeat (TICK) @(negedge clk);
    end
    // R3: above low but not high holds
    fb_gt_low = 1;
    for (int k = 0; k < 2; k++) begin
      repeat (TICK) @(negedge clk);
      check("R3 hold", valley_target, 7);
    end
    // R4: above high counts down to 1
    fb_gt_high = 1;
    for (int k = 1; k <= 7; k++) begin
      repeat (TICK) @(negedge clk);
      check("R4 count down", valley_target, (7 - k < 1) ? 1 : 7 - k);
    end
    fb_gt_low = 0; fb_gt_high = 0;
    repeat (TICK) @(negedge clk);
    check("R4 mixed period still down", valley_target, 1);
    repeat (TICK) @(negedge clk);
    check("R2 up after clean period", valley_target, 2);
    repeat (TICK) @(negedge clk);
    check("R2 up again", valley_target, 3);
    // R3: one short low-threshold excursion holds the whole period
    fb_gt_low = 1; @(negedge clk); fb_gt_low = 0;
    repeat (TICK - 1) @(negedge clk);
    check("R3 single-cycle excursion holds", valley_target, 3);
    repeat (TICK) @(negedge clk);
    check("R2 resumes", valley_target, 4);
    // R5: reset threshold and force request
    fb_gt_reset = 1; @(negedge clk); fb_gt_reset = 0;
    check("R5 reset threshold", valley_target, 1);
    repeat (TICK) @(negedge clk);
    check("R2 after fast reset", valley_target, 2);
    force_one = 1; @(negedge clk); force_one = 0;
    check("R5 force one", valley_target, 1);
    repeat (TICK) @(negedge clk);
    // R1: init while gate is high
    while (gate !== 1'b1) @(negedge clk);
    init_req = 1; @(negedge clk); init_req = 0;
    check("R1 init gate", gate, 0);
    check("R1 init target", valley_target, 1);

    // R12 / R9: no trip, no crossings
    fb_gt_low = 1;
    measure(0, 0, on_len, off_len);
    check("R12 max on", on_len, ONM);
    check("R9 max off", off_len, OFFM);
    // R10: early trip ignored
    measure(2, 0, on_len, off_len);
    check("R10 early trip ignored", on_len, ONM);
    // R11: trip after blanking
    measure(3, 0, on_len, off_len);
    check("R11 late trip", on_len, 7);
    measure(1, 0, on_len, off_len);
    check("R10 minimum on with trip held", on_len, LEB);

    // R6 R7 R8: valley sweep over every target
    for (int n = 1; n <= 7; n++) begin
      fb_gt_low = 0;
      while (valley_target != 3'(n)) @(negedge clk);
      fb_gt_low = 1;
      for (int a = 0; a < 2; a++) begin
        zc_above_rs = a[0];
        for (int p = 0; p <= 3; p++) begin
          measure(1, p, on_len, off_len);
          check(p == 0 ? "R9 off sweep" : (n == 7 && p == 1 ? "R6 saturating count" : "R8 R7 valley sweep"),
                off_len, exp_off(n, p, a[0]));
          check("R11 trip on sweep", on_len, LEB);
          check("R3 target held", valley_target, n);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule